// File: doc/BRIEF.md
# Page Commit Engine for a Byte-Addressed Nonvolatile Array

This block takes a page of up to sixteen bytes that a serial front end has already collected, and writes it into a byte-addressed storage array. A commit request carries a base address, a byte-enable mask and the data bytes. Once a request is accepted, the engine holds `busy_o` for a fixed, programmable number of cycles. That time is the same whether one byte or a whole page is stored. The front end uses `busy_o` to refuse new traffic. Bytes are placed from the base address upward, and the offset wraps inside the page, so the page bits of the address never carry.

A write-protect input can cancel a commit, but only once a cancel window has opened. The front end opens the window with `arm_i` at the clock edge that captures the last bit of the first data byte. Before that edge, write-protect is ignored. After it, write-protect either refuses the pending commit or aborts a write in progress. An abort returns the engine to idle at once and flags the bytes it was writing as undefined. A low-supply flag blocks any commit and aborts a write in progress in the same way. Erased storage reads as FFh.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `aborted_o` are 0. Every address reads FFh with `rd_undef_o` 0.
- R2: An accepted commit raises `busy_o` in the cycle after the request and holds it for exactly WRITE_CYCLES cycles for any mask. `done_o` is high for the one cycle in which `busy_o` has just fallen.
- R3: When a commit completes, data byte i (bits 8i+7:8i of `data_i`) is stored when mask bit i is 1. The target address keeps the page bits of the base (all but the low log2(PAGE_BYTES) bits), and its low bits are the base's low bits plus i, modulo PAGE_BYTES. Bytes whose mask bit is 0 are left unchanged.
- R4: A commit request or `arm_i` that arrives while `busy_o` is high has no effect. The running write keeps its length and its data, and no cancel window is opened.
- R5: A high `wp_i` before the cancel window has been opened by `arm_i` has no effect on the commit that follows.
- R6: If `wp_i` is high at the commit request, or was high in any idle cycle after `arm_i`, the commit is refused. `aborted_o` pulses for one cycle, `busy_o` stays 0 and no byte changes.
- R7: A high `wp_i` while `busy_o` is high clears `busy_o` at the next edge and pulses `aborted_o`; `done_o` does not pulse. Every byte selected by the mask reads with `rd_undef_o` 1, and bytes outside the mask are untouched.
- R8: A high `low_vcc_i` refuses a commit request as in R6, and aborts a write in progress as in R7.
- R9: A later completed commit to an undefined byte stores the new data and clears its `rd_undef_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | Commit request, one cycle |
| base_addr_i | input | ADDR_W | Address of data byte 0 |
| mask_i | input | PAGE_BYTES | Byte enables, bit i for data byte i |
| data_i | input | 8*PAGE_BYTES | Data bytes, byte i at bits 8i+7:8i |
| arm_i | input | 1 | Opens the cancel window (first data byte fully captured) |
| wp_i | input | 1 | Write protect, active high |
| low_vcc_i | input | 1 | Supply below the rewrite threshold |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Stored byte at `rd_addr_i` |
| rd_undef_o | output | 1 | Byte at `rd_addr_i` was hit by an abort |
| busy_o | output | 1 | Write time running |
| done_o | output | 1 | Commit completed, one cycle |
| aborted_o | output | 1 | Commit refused or aborted, one cycle |

## Verification
The bench builds the engine with WRITE_CYCLES=12 and ADDR_W=6. The short write time lets every busy window be counted cycle by cycle. It also leaves room to inject a request, an arm or a protect pulse at a chosen point inside that window. The 64-byte array holds four pages, so after every commit or abort the whole array can be compared with a reference model. The wrap cases then show both that the offset wraps and that the neighbouring pages stay untouched.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {OUT_NONE, OUT_DONE, OUT_ABORT} outcome_e;
endpackage

// File: rtl/pce_window.sv
module pce_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic commit_i,
  input  logic arm_i,
  input  logic wp_i,
  input  logic low_vcc_i,
  output logic start_o,
  output logic refuse_o
);
  logic armed_q, killed_q, take;

  assign take     = commit_i && !busy_i;
  // the request itself lies inside the window, so wp at that edge counts
  assign refuse_o = take && (killed_q || wp_i || low_vcc_i);
  assign start_o  = take && !refuse_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      killed_q <= 1'b0;
    end else if (take) begin
      armed_q  <= 1'b0;
      killed_q <= 1'b0;
    end else if (!busy_i) begin
      if (arm_i) armed_q <= 1'b1;
      if (armed_q && wp_i) killed_q <= 1'b1;
    end
  end

  AST_BUSY_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && commit_i |-> !start_o && !refuse_o); // R4
endmodule

// File: rtl/pce_timer.sv
module pce_timer #(
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic busy_o,
  output logic finish_o,
  output logic abort_o
);
  localparam int unsigned CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WRITE_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign abort_o  = busy_q && cancel_i;
  assign finish_o = busy_q && !cancel_i && (cnt_q == '0);
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (abort_o || finish_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cancel_i && cnt_q != '0 |=> busy_q); // R2
  AST_CANCEL_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cancel_i |=> !busy_q); // R7
endmodule

// File: rtl/pce_array.sv
module pce_array #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_BYTES = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    poison_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [8*PAGE_BYTES-1:0] data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output pce_pkg::byte_t          rd_data_o,
  output logic                    rd_undef_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned OW    = $clog2(PAGE_BYTES);

  pce_pkg::byte_t    mem_q [DEPTH];
  logic [DEPTH-1:0]  undef_q;
  logic [ADDR_W-1:0] lane_addr [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
    // offset wraps inside the page, page bits never carry
    assign lane_addr[i] = {base_i[ADDR_W-1:OW], OW'(base_i[OW-1:0] + OW'(i))};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
      undef_q <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_i[i] && wr_en_i) begin
          mem_q[lane_addr[i]]   <= data_i[8*i +: 8];
          undef_q[lane_addr[i]] <= 1'b0;
        end else if (mask_i[i] && poison_i) begin
          undef_q[lane_addr[i]] <= 1'b1;
        end
      end
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign rd_undef_o = undef_q[rd_addr_i];

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && poison_i)); // R7
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PAGE_BYTES   = 16,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [ADDR_W-1:0]       base_addr_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [8*PAGE_BYTES-1:0] data_i,
  input  logic                    arm_i,
  input  logic                    wp_i,
  input  logic                    low_vcc_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic                    rd_undef_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    aborted_o
);
  import pce_pkg::*;

  logic                    start, refuse, finish, abort_run, busy;
  logic [ADDR_W-1:0]       base_q;
  logic [PAGE_BYTES-1:0]   mask_q;
  logic [8*PAGE_BYTES-1:0] data_q;
  outcome_e                outcome_d, outcome_q;

  pce_window i_window (
    .clk_i, .rst_ni,
    .busy_i    (busy),
    .commit_i,
    .arm_i,
    .wp_i,
    .low_vcc_i,
    .start_o   (start),
    .refuse_o  (refuse)
  );

  pce_timer #(.WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk_i, .rst_ni,
    .start_i   (start),
    .cancel_i  (wp_i || low_vcc_i),
    .busy_o    (busy),
    .finish_o  (finish),
    .abort_o   (abort_run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else if (start) begin
      base_q <= base_addr_i;
      mask_q <= mask_i;
      data_q <= data_i;
    end
  end

  pce_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_array (
    .clk_i, .rst_ni,
    .wr_en_i    (finish),
    .poison_i   (abort_run),
    .base_i     (base_q),
    .mask_i     (mask_q),
    .data_i     (data_q),
    .rd_addr_i,
    .rd_data_o,
    .rd_undef_o
  );

  always_comb begin
    outcome_d = OUT_NONE;
    if (finish)                  outcome_d = OUT_DONE;
    else if (abort_run || refuse) outcome_d = OUT_ABORT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outcome_q <= OUT_NONE;
    else         outcome_q <= outcome_d;
  end

  assign busy_o    = busy;
  assign done_o    = (outcome_q == OUT_DONE);
  assign aborted_o = (outcome_q == OUT_ABORT);

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o); // R2
  AST_DONE_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && aborted_o)); // R7
  AST_CLEAN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i && !wp_i && !low_vcc_i)); // R6 R8
endmodule

// File: tb/test_page_commit_engine.sv
`timescale 1ns/1ps
module test_page_commit_engine;
  localparam int AW = 6;
  localparam int PB = 16;
  localparam int WC = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic commit = 0, arm = 0, wp = 0, low_vcc = 0;
  logic [AW-1:0] base = '0, rd_addr = '0;
  logic [PB-1:0] mask = '0;
  logic [8*PB-1:0] data = '0;
  logic [7:0] rd_data;
  logic rd_undef, busy, done, aborted;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [DEPTH];
  logic ref_undef [DEPTH];

  always #2.5 clk = ~clk;

  page_commit_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) i_page_commit_engine (
    .clk_i(clk), .rst_ni(rst_n), .commit_i(commit), .base_addr_i(base), .mask_i(mask),
    .data_i(data), .arm_i(arm), .wp_i(wp), .low_vcc_i(low_vcc), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_undef_o(rd_undef), .busy_o(busy), .done_o(done),
    .aborted_o(aborted));

  // base[29:24] mask[23:8] seed[7:0]
  localparam logic [29:0] VEC [6] = '{
    {6'h00, 16'hFFFF, 8'h10},
    {6'h13, 16'h0001, 8'hA0},
    {6'h2E, 16'h000F, 8'h55},
    {6'h35, 16'h0A05, 8'h77},
    {6'h00, 16'h00F0, 8'h01},
    {6'h3F, 16'h8001, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8*PB-1:0] make_data(input logic [7:0] seed);
    logic [8*PB-1:0] d;
    for (int i = 0; i < PB; i++) d[8*i +: 8] = seed + 8'(i * 13);
    return d;
  endfunction

  function automatic logic [AW-1:0] lane(input logic [AW-1:0] b, input int i);
    return {b[AW-1:4], 4'(b[3:0] + 4'(i))};
  endfunction

  task automatic model(input logic [AW-1:0] b, input logic [PB-1:0] m,
                       input logic [7:0] seed, input bit poison);
    logic [8*PB-1:0] d = make_data(seed);
    for (int i = 0; i < PB; i++) if (m[i]) begin
      if (poison) ref_undef[lane(b, i)] = 1'b1;
      else begin
        ref_mem[lane(b, i)]   = d[8*i +: 8];
        ref_undef[lane(b, i)] = 1'b0;
      end
    end
  endtask

  task automatic compare_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      chk(req, rd_undef, ref_undef[a]);
      if (!ref_undef[a]) chk(req, rd_data, ref_mem[a]);
    end
    @(negedge clk);
  endtask

  task automatic request(input logic [AW-1:0] b, input logic [PB-1:0] m, input logic [7:0] seed);
    @(negedge clk);
    base = b; mask = m; data = make_data(seed); commit = 1;
    @(negedge clk);
    commit = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    for (int a = 0; a < DEPTH; a++) begin ref_mem[a] = 8'hFF; ref_undef[a] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 aborted", aborted, 0);
    compare_all("R1 erased");

    // R2 R3 vector walk
    for (int v = 0; v < 6; v++) begin
      request(VEC[v][29:24], VEC[v][23:8], VEC[v][7:0]);
      chk("R2 busy rise", busy, 1);
      wait_idle(n);
      chk("R2 busy length", n, WC);
      chk("R2 done pulse", done, 1);
      chk("R2 no abort", aborted, 0);
      @(negedge clk);
      chk("R2 done falls", done, 0);
      model(VEC[v][29:24], VEC[v][23:8], VEC[v][7:0], 0);
      compare_all("R3 contents");
    end

    // R4 request and arm during busy are dropped
    request(6'h10, 16'hFFFF, 8'h20);
    base = 6'h20; data = make_data(8'h99); commit = 1; arm = 1;
    @(negedge clk);
    commit = 0; arm = 0;
    wait_idle(n);
    chk("R4 length kept", n, WC - 1);
    chk("R4 done", done, 1);
    model(6'h10, 16'hFFFF, 8'h20, 0);
    compare_all("R4 second request ignored");
    wp = 1; @(negedge clk); wp = 0;
    request(6'h22, 16'h0003, 8'h31);
    chk("R4 arm ignored, commit accepted", busy, 1);
    wait_idle(n);
    model(6'h22, 16'h0003, 8'h31, 0);
    compare_all("R4 contents");

    // R5 wp before arm ignored
    wp = 1; @(negedge clk); wp = 0; arm = 1; @(negedge clk); arm = 0;
    request(6'h08, 16'h0300, 8'h42);
    chk("R5 accepted", busy, 1);
    wait_idle(n);
    chk("R5 done", done, 1);
    model(6'h08, 16'h0300, 8'h42, 0);
    compare_all("R5 contents");

    // R6 wp inside window before commit
    arm = 1; @(negedge clk); arm = 0; wp = 1; @(negedge clk); wp = 0;
    request(6'h24, 16'h00FF, 8'h66);
    chk("R6 refused busy", busy, 0);
    chk("R6 aborted pulse", aborted, 1);
    @(negedge clk);
    chk("R6 aborted falls", aborted, 0);
    compare_all("R6 unchanged");
    // R6 wp at the commit edge
    @(negedge clk);
    base = 6'h24; mask = 16'h00FF; data = make_data(8'h67); commit = 1; wp = 1;
    @(negedge clk);
    commit = 0; wp = 0;
    chk("R6 wp at request busy", busy, 0);
    chk("R6 wp at request aborted", aborted, 1);
    compare_all("R6 unchanged 2");

    // R7 wp during busy
    request(6'h04, 16'h0F0F, 8'h88);
    @(negedge clk); @(negedge clk);
    wp = 1; @(negedge clk); wp = 0;
    chk("R7 busy drops", busy, 0);
    chk("R7 aborted", aborted, 1);
    chk("R7 no done", done, 0);
    @(negedge clk);
    chk("R7 no late done", done, 0);
    model(6'h04, 16'h0F0F, 8'h88, 1);
    compare_all("R7 undefined bytes");

    // R9 rewrite clears undefined flag
    request(6'h04, 16'h0F0F, 8'h89);
    wait_idle(n);
    chk("R9 done", done, 1);
    model(6'h04, 16'h0F0F, 8'h89, 0);
    compare_all("R9 rewritten");

    // R8 low supply at request, then during busy
    @(negedge clk);
    base = 6'h30; mask = 16'hFFFF; data = make_data(8'hE0); commit = 1; low_vcc = 1;
    @(negedge clk);
    commit = 0; low_vcc = 0;
    chk("R8 refused busy", busy, 0);
    chk("R8 refused aborted", aborted, 1);
    compare_all("R8 unchanged");
    request(6'h30, 16'h0101, 8'hE1);
    repeat (5) @(negedge clk);
    low_vcc = 1; @(negedge clk); low_vcc = 0;
    chk("R8 busy drops", busy, 0);
    chk("R8 aborted", aborted, 1);
    chk("R8 no done", done, 0);
    model(6'h30, 16'h0101, 8'hE1, 1);
    compare_all("R8 undefined bytes");

    report();
  end
endmodule